// File: doc/BRIEF.md
# Multi-Cycle Shared-ALU Processor Datapath

This block is the register-transfer half of a 32-bit processor that spends several clock cycles on each instruction. One ALU and one unified memory port are reused in every phase. Values that must survive from one phase to the next sit in internal latches: program counter, instruction register, two operand latches, an ALU result latch and a memory data latch. A 32-entry register file with a hard-wired zero entry sits beside them. The datapath does nothing by itself. An external sequencer drives a set of per-cycle strobes and selects, and reads back the opcode, the function field and an operand-equality flag to pick its next state.

With the right strobe sequence the datapath carries out register-register ALU operations, word loads, word stores, branch-on-equal and absolute jumps. The decode phase always computes the branch target, whether or not the instruction turns out to be a branch. The ALU is then free during execute to compare the operands.

Memory sits outside the block. The block presents an address, write data and a write enable, and expects the addressed word back on the read-data input within the same cycle.

Top module: `mc_proc_datapath`

## Requirements
- R1: When `irWrite` is high, the instruction register captures `memRdata` at the clock edge. With `aluSrcA`=0, `aluSrcB`=01 (constant 4), `aluOp`=00 (add), `pcSource`=00 and `pcWrite`=1, PC advances by 4 at the same edge.
- R2: When `opLatchWrite` is high, operand latch A takes register IR[25:21] and B takes register IR[20:16]. With `aluSrcA`=0, `aluSrcB`=11 and `aluOutWrite`=1, the result latch takes PC + (sign-extended IR[15:0] shifted left by 2).
- R3: With `aluSrcA`=1, `aluSrcB`=00 and `aluOp`=1x, the ALU operation comes from IR[5:0]: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR. Any other code adds. With `regWrite`=1, `regDst`=1 and `memToReg`=0, the latched result is written to register IR[15:11].
- R4: `aluSrcB`=10 selects the sign-extended IR[15:0], so A + offset forms the effective address. `mdrWrite` captures `memRdata`. `regWrite` with `regDst`=0 and `memToReg`=1 writes the memory data latch to register IR[20:16].
- R5: `memWe` follows `memWrite`, and `memWdata` always carries operand latch B.
- R6: `pcWriteCond`=1 with `pcSource`=01 loads PC from the result latch only when A equals B. Otherwise PC is unchanged.
- R7: `pcWrite` with `pcSource`=10 loads PC with {PC[31:28], IR[25:0], 2'b00}.
- R8: Register 0 reads as zero, and writes to it are discarded.
- R9: `memAddr` is PC when `addrSel`=0 and the result latch when `addrSel`=1. PC resets to 0.
- R10: Each internal register changes only when its own enable is high (for PC: `pcWrite`, or `pcWriteCond` with equal operands).
- R11: `opcode` is IR[31:26], `funct` is IR[5:0], and `operandsEqual` is high exactly when A equals B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pcWrite | input | 1 | Unconditional PC load |
| pcWriteCond | input | 1 | PC load when operands are equal |
| irWrite | input | 1 | Instruction register load |
| opLatchWrite | input | 1 | Operand latches A/B load |
| aluOutWrite | input | 1 | ALU result latch load |
| mdrWrite | input | 1 | Memory data latch load |
| regWrite | input | 1 | Register file write |
| regDst | input | 1 | Write index: 1 = IR[15:11], 0 = IR[20:16] |
| memToReg | input | 1 | Write data: 1 = memory data latch, 0 = result latch |
| addrSel | input | 1 | Memory address: 0 = PC, 1 = result latch |
| aluSrcA | input | 1 | ALU A input: 0 = PC, 1 = latch A |
| aluSrcB | input | 2 | ALU B input: 00 B, 01 constant 4, 10 offset, 11 offset<<2 |
| aluOp | input | 2 | 00 add, 01 subtract, 1x by function field |
| pcSource | input | 2 | PC source: 00 ALU, 01 result latch, 10 jump target |
| memWrite | input | 1 | Memory write request |
| memRdata | input | 32 | Memory read word for `memAddr`, same cycle |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memWe | output | 1 | Memory write enable |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| operandsEqual | output | 1 | Latch A equals latch B |

## Verification
The embedded properties assume that `rstN` is held low for at least one edge before any strobe rises. They also assume that `memRdata` is valid whenever `irWrite` or `mdrWrite` is high. The bench plays the sequencer and sets every strobe from a fixed per-phase recipe, clearing it a fixed delay after each edge. Its memory model answers reads combinationally from the current address, so both assumptions hold. It places code below byte 0x200 and data above 0x300 and issues a jump back to zero before code could reach data, so no fetch ever reads a data word.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_OR  = 2'd3
  } aluFnT;

  typedef struct packed {
    logic       pcLoad;
    logic       irWrite;
    logic       abWrite;
    logic       aluOutWrite;
    logic       mdrWrite;
    logic       regWrite;
    logic       regDst;
    logic       memToReg;
    logic       addrSel;
    logic       memWrite;
    logic       srcA;
    logic [1:0] srcB;
    aluFnT      aluFn;
    logic [1:0] pcSrc;
  } ctrlT;

  localparam logic [5:0] FUNCT_ADD = 6'h20;
  localparam logic [5:0] FUNCT_SUB = 6'h22;
  localparam logic [5:0] FUNCT_AND = 6'h24;
  localparam logic [5:0] FUNCT_OR  = 6'h25;
endpackage

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       pcWrite,
  input  logic       pcWriteCond,
  input  logic       irWrite,
  input  logic       opLatchWrite,
  input  logic       aluOutWrite,
  input  logic       mdrWrite,
  input  logic       regWrite,
  input  logic       regDst,
  input  logic       memToReg,
  input  logic       addrSel,
  input  logic       memWrite,
  input  logic       aluSrcA,
  input  logic [1:0] aluSrcB,
  input  logic [1:0] aluOp,
  input  logic [1:0] pcSource,
  input  logic [5:0] functField,
  input  logic       eqFlag,
  output ctrlT       ctrl
);
  aluFnT functFn;

  // Function-field decode; unlisted codes fall back to add
  always_comb begin
    case (functField)
      FUNCT_SUB: functFn = FN_SUB;
      FUNCT_AND: functFn = FN_AND;
      FUNCT_OR:  functFn = FN_OR;
      default:   functFn = FN_ADD;
    endcase
  end

  always_comb begin
    ctrl             = '0;
    ctrl.pcLoad      = pcWrite | (pcWriteCond & eqFlag);
    ctrl.irWrite     = irWrite;
    ctrl.abWrite     = opLatchWrite;
    ctrl.aluOutWrite = aluOutWrite;
    ctrl.mdrWrite    = mdrWrite;
    ctrl.regWrite    = regWrite;
    ctrl.regDst      = regDst;
    ctrl.memToReg    = memToReg;
    ctrl.addrSel     = addrSel;
    ctrl.memWrite    = memWrite;
    ctrl.srcA        = aluSrcA;
    ctrl.srcB        = aluSrcB;
    ctrl.pcSrc       = pcSource;
    case (aluOp)
      2'b00:   ctrl.aluFn = FN_ADD;
      2'b01:   ctrl.aluFn = FN_SUB;
      default: ctrl.aluFn = functFn;
    endcase
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int XLEN = 32,
  parameter int REGS = 32,
  localparam int RAW = $clog2(REGS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [RAW-1:0]  raddrA,
  input  logic [RAW-1:0]  raddrB,
  output logic [XLEN-1:0] rdataA,
  output logic [XLEN-1:0] rdataB,
  input  logic            we,
  input  logic [RAW-1:0]  waddr,
  input  logic [XLEN-1:0] wdata
);
  logic [REGS*XLEN-1:0] flat;

  for (genvar i = 0; i < REGS; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign flat[XLEN-1:0] = '0;
    end else begin : g_reg
      logic [XLEN-1:0] q;
      always_ff @(posedge clk) begin
        if (!rstN)                             q <= '0;
        else if (we && waddr == RAW'(i))        q <= wdata;
      end
      assign flat[i*XLEN +: XLEN] = q;
    end
  end

  assign rdataA = flat[raddrA*XLEN +: XLEN];
  assign rdataB = flat[raddrB*XLEN +: XLEN];

  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rstN)
    (we && waddr != '0) |=> flat[$past(waddr)*XLEN +: XLEN] == $past(wdata));
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int REGS = 32,
  localparam int RAW = $clog2(REGS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlT            ctrl,
  input  logic [XLEN-1:0] memRdata,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  output logic            memWe,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic            eqFlag
);
  logic [XLEN-1:0] pc, ir, aLat, bLat, aluOut, mdr;
  logic [XLEN-1:0] rfA, rfB, sext, aluInA, aluInB, aluRes, pcNext, jumpTgt, wbData;
  logic [RAW-1:0]  wbAddr;

  assign sext    = {{(XLEN-16){ir[15]}}, ir[15:0]};
  assign jumpTgt = {pc[XLEN-1:28], ir[25:0], 2'b00};
  assign aluInA  = ctrl.srcA ? aLat : pc;

  always_comb begin
    case (ctrl.srcB)
      2'd0:    aluInB = bLat;
      2'd1:    aluInB = XLEN'(4);
      2'd2:    aluInB = sext;
      default: aluInB = sext << 2;
    endcase
  end

  always_comb begin
    case (ctrl.aluFn)
      FN_SUB:  aluRes = aluInA - aluInB;
      FN_AND:  aluRes = aluInA & aluInB;
      FN_OR:   aluRes = aluInA | aluInB;
      default: aluRes = aluInA + aluInB;
    endcase
  end

  always_comb begin
    case (ctrl.pcSrc)
      2'd1:    pcNext = aluOut;
      2'd2:    pcNext = jumpTgt;
      default: pcNext = aluRes;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= '0; ir <= '0; aLat <= '0; bLat <= '0; aluOut <= '0; mdr <= '0;
    end else begin
      if (ctrl.pcLoad)      pc     <= pcNext;
      if (ctrl.irWrite)     ir     <= memRdata;
      if (ctrl.abWrite) begin
        aLat <= rfA;
        bLat <= rfB;
      end
      if (ctrl.aluOutWrite) aluOut <= aluRes;
      if (ctrl.mdrWrite)    mdr    <= memRdata;
    end
  end

  assign wbAddr = ctrl.regDst ? ir[11 +: RAW] : ir[16 +: RAW];
  assign wbData = ctrl.memToReg ? mdr : aluOut;

  mc_regfile #(.XLEN(XLEN), .REGS(REGS)) i_rf (
    .clk(clk), .rstN(rstN),
    .raddrA(ir[21 +: RAW]), .raddrB(ir[16 +: RAW]),
    .rdataA(rfA), .rdataB(rfB),
    .we(ctrl.regWrite), .waddr(wbAddr), .wdata(wbData)
  );

  assign memAddr  = ctrl.addrSel ? aluOut : pc;
  assign memWdata = bLat;
  assign memWe    = ctrl.memWrite;
  assign opcode   = ir[31:26];
  assign funct    = ir[5:0];
  assign eqFlag   = (aLat == bLat);

  p_ir_capture_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.irWrite |=> ir == $past(memRdata));
  p_ab_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.abWrite |=> $stable(aLat) && $stable(bLat));
  p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.pcLoad |=> $stable(pc));
  p_jump_field_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.pcLoad && ctrl.pcSrc == 2'd2) |=> pc[27:0] == {$past(ir[25:0]), 2'b00});
  p_mdr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.mdrWrite |=> $stable(mdr));
endmodule

// File: rtl/mc_proc_datapath.sv
module mc_proc_datapath
  import mc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int REGS = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pcWrite,
  input  logic            pcWriteCond,
  input  logic            irWrite,
  input  logic            opLatchWrite,
  input  logic            aluOutWrite,
  input  logic            mdrWrite,
  input  logic            regWrite,
  input  logic            regDst,
  input  logic            memToReg,
  input  logic            addrSel,
  input  logic            aluSrcA,
  input  logic [1:0]      aluSrcB,
  input  logic [1:0]      aluOp,
  input  logic [1:0]      pcSource,
  input  logic            memWrite,
  input  logic [XLEN-1:0] memRdata,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  output logic            memWe,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic            operandsEqual
);
  ctrlT ctrl;

  mc_ctrl i_ctrl (
    .pcWrite(pcWrite), .pcWriteCond(pcWriteCond), .irWrite(irWrite),
    .opLatchWrite(opLatchWrite), .aluOutWrite(aluOutWrite), .mdrWrite(mdrWrite),
    .regWrite(regWrite), .regDst(regDst), .memToReg(memToReg), .addrSel(addrSel),
    .memWrite(memWrite), .aluSrcA(aluSrcA), .aluSrcB(aluSrcB), .aluOp(aluOp),
    .pcSource(pcSource), .functField(funct), .eqFlag(operandsEqual), .ctrl(ctrl)
  );

  mc_datapath #(.XLEN(XLEN), .REGS(REGS)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .opcode(opcode), .funct(funct), .eqFlag(operandsEqual)
  );

  p_branch_not_taken_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pcWriteCond && !pcWrite && !operandsEqual && !addrSel) |=> (!addrSel -> $stable(memAddr)));
endmodule

// File: tb/test_mc_proc_datapath.sv
module test_mc_proc_datapath;
  logic clk = 0, rstN = 0;
  logic pcWrite, pcWriteCond, irWrite, opLatchWrite, aluOutWrite, mdrWrite;
  logic regWrite, regDst, memToReg, addrSel, aluSrcA, memWrite;
  logic [1:0] aluSrcB, aluOp, pcSource;
  logic [31:0] memRdata, memAddr, memWdata;
  logic memWe, operandsEqual;
  logic [5:0] opcode, funct;

  logic [31:0] mem [256];
  logic [31:0] expReg [32];
  logic [31:0] expPc;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mc_proc_datapath i_mc_proc_datapath (.*);

  assign memRdata = mem[memAddr[9:2]];
  always @(posedge clk) if (memWe) mem[memAddr[9:2]] <= memWdata;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    {pcWrite, pcWriteCond, irWrite, opLatchWrite, aluOutWrite, mdrWrite} = '0;
    {regWrite, regDst, memToReg, addrSel, aluSrcA, memWrite} = '0;
    aluSrcB = 0; aluOp = 0; pcSource = 0;
  endtask

  task automatic edgeStep();
    @(posedge clk); #2; clr();
  endtask

  function automatic logic [31:0] sx(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  // fetch + decode; pcTag names the requirement the PC check stands for
  task automatic fetchDecode(logic [31:0] instr, string pcTag);
    mem[expPc[9:2]] = instr;
    irWrite = 1; aluSrcB = 2'd1; pcWrite = 1;
    #1 chk({pcTag, " pc"}, memAddr, expPc);
    edgeStep();
    expPc += 4;
    chk("R11 opcode", {26'd0, opcode}, {26'd0, instr[31:26]});
    chk("R11 funct", {26'd0, funct}, {26'd0, instr[5:0]});
    opLatchWrite = 1; aluOutWrite = 1; aluSrcB = 2'd3;
    edgeStep();
    chk("R11 eq", {31'd0, operandsEqual},
        {31'd0, expReg[instr[25:21]] == expReg[instr[20:16]]});
  endtask

  task automatic jumpTo(logic [25:0] t);
    fetchDecode({6'h02, t}, "R1");
    pcWrite = 1; pcSource = 2'd2;
    edgeStep();
    expPc = {expPc[31:28], t, 2'b00};
  endtask

  task automatic wrap();
    if (expPc >= 32'h200) jumpTo(26'd0);
  endtask

  task automatic rOp(logic [5:0] fn, int rd, int rs, int rt);
    logic [31:0] a, b, r;
    wrap();
    a = expReg[rs]; b = expReg[rt];
    case (fn)
      6'h22: r = a - b;
      6'h24: r = a & b;
      6'h25: r = a | b;
      default: r = a + b;
    endcase
    fetchDecode({6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn}, "R1");
    aluSrcA = 1; aluOp = 2'b10; aluOutWrite = 1;
    edgeStep();
    regWrite = 1; regDst = 1;
    edgeStep();
    if (rd != 0) expReg[rd] = r;
  endtask

  task automatic ld(int rt, int base, logic [15:0] imm);
    logic [31:0] ea;
    wrap();
    ea = expReg[base] + sx(imm);
    fetchDecode({6'h23, 5'(base), 5'(rt), imm}, "R1");
    aluSrcA = 1; aluSrcB = 2'd2; aluOutWrite = 1;
    edgeStep();
    addrSel = 1; mdrWrite = 1;
    #1 chk("R4 load address", memAddr, ea);
    edgeStep();
    regWrite = 1; memToReg = 1;
    edgeStep();
    if (rt != 0) expReg[rt] = mem[ea[9:2]];
  endtask

  task automatic st(int rt, int base, logic [15:0] imm, string tag);
    logic [31:0] ea;
    wrap();
    ea = expReg[base] + sx(imm);
    fetchDecode({6'h2B, 5'(base), 5'(rt), imm}, "R1");
    aluSrcA = 1; aluSrcB = 2'd2; aluOutWrite = 1;
    edgeStep();
    addrSel = 1; memWrite = 1;
    #1 chk("R5 store address", memAddr, ea);
    chk("R5 store we", {31'd0, memWe}, 32'd1);
    edgeStep();
    chk(tag, mem[ea[9:2]], expReg[rt]);
  endtask

  task automatic beq(int rs, int rt, logic [15:0] imm);
    wrap();
    fetchDecode({6'h04, 5'(rs), 5'(rt), imm}, "R1");
    aluSrcA = 1; aluOp = 2'b01; pcWriteCond = 1; pcSource = 2'd1;
    edgeStep();
    if (expReg[rs] == expReg[rt]) expPc = expPc + (sx(imm) << 2);
    addrSel = 0;
    #1 chk("R6 branch pc", memAddr, expPc);
  endtask

  logic [31:0] vals [6] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h12345678};
  logic [5:0] fns [4] = '{6'h20, 6'h22, 6'h24, 6'h25};

  initial begin
    clr();
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 32; i++) expReg[i] = '0;
    for (int k = 0; k < 6; k++) mem[192 + k] = vals[k];
    mem[200] = 32'h340;
    mem[205] = 32'hCAFE0123;
    expPc = 0;
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    #1 chk("R9 reset pc", memAddr, 32'h0);
    chk("R11 reset opcode", {26'd0, opcode}, 32'd0);
    chk("R5 reset we", {31'd0, memWe}, 32'd0);

    for (int k = 0; k < 6; k++) ld(k + 1, 0, 16'(32'h300 + 4 * k));
    ld(10, 0, 16'h320);
    ld(11, 10, 16'hFFF4);                 // negative offset: 0x340-12
    st(11, 0, 16'h380, "R4 load negative offset");
    st(11, 10, 16'hFFF8, "R5 store negative offset");

    // R2/R3 sweep over operand pairs and ALU functions
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int f = 0; f < 4; f++) begin
          rOp(fns[f], 20, i + 1, j + 1);
          st(20, 0, 16'h380, "R3 alu result");
        end

    rOp(6'h27, 21, 3, 6);                 // unlisted code adds
    st(21, 0, 16'h384, "R3 default add");
    rOp(6'h25, 0, 5, 6);                  // write to r0 discarded
    st(0, 0, 16'h388, "R8 r0 zero");
    ld(0, 0, 16'h314);
    st(0, 0, 16'h388, "R8 r0 load ignored");

    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        beq(i + 1, j + 1, (expPc >= 32'h40) ? 16'hFFFC : 16'h0005);

    // R10: hold with no enables while memory under PC changes
    begin
      logic [5:0] opSeen;
      wrap();
      fetchDecode({6'h2B, 5'd0, 5'd1, 16'h0390}, "R1");
      opSeen = opcode;
      mem[expPc[9:2]] = 32'hFFFFFFFF;
      mem[(expPc - 4) >> 2] = 32'hFFFFFFFF;
      repeat (3) edgeStep();
      #1 chk("R10 pc hold", memAddr, expPc);
      chk("R10 ir hold", {26'd0, opcode}, {26'd0, opSeen});
      aluSrcA = 1; aluSrcB = 2'd2; aluOutWrite = 1;
      edgeStep();
      addrSel = 1; memWrite = 1;
      #1 chk("R9 data address", memAddr, 32'h390);
      chk("R10 B held", memWdata, expReg[1]);
      edgeStep();
      mem[expPc[9:2]] = 0;
    end

    jumpTo(26'h0000050);
    #1 chk("R7 jump pc", memAddr, 32'h140);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    #5 $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule